// File: doc/BRIEF.md
# Peripheral-Paced DMA Transmit Channel

This block is a single memory-to-peripheral DMA channel. Software fills a small internal table of buffer descriptors through a register-style configuration port. Each descriptor holds a start address, a byte count and an optional keep/skip pattern. Software then sets a go bit. The channel walks the chain of descriptors from entry 0 by itself. It reads memory one access-width word at a time into an eight-word staging FIFO, ahead of demand. It hands the words to the peripheral's FIFO register only when the peripheral raises its request line.

Each request opens one burst. A burst carries no more words than the programmed burst length, and it never crosses the end of a buffer. After the burst the channel goes idle until it sees the request line high again. A request that arrives while the staging FIFO is empty is remembered, and it is served once data lands. The acknowledge line is high exactly while a word is on the peripheral write-data port.

When the last word of the last buffer leaves, the channel pulses a done flag and its busy status falls. A descriptor whose byte count is unusable is refused with an error flag, and no memory read is made for it.

Top module: `ptx_dma_chan`

## Requirements
- R1: After reset, busy, error, acknowledge, memory request and done are all low, and the control and status registers (offsets 0 and 1) read as zero.
- R2: A descriptor whose length is zero or not a whole multiple of the access width sets the error flag (status bit 1) and clears busy (status bit 0), and the channel issues no memory request for it.
- R3: The acknowledge line is high exactly in the cycles where a word is presented on the write-data port. The word holds the bytes from its fetch address upward, little-endian, and its bytes above the access width are zero.
- R4: Each burst moves at most the smaller of the burst length (control bits 7:4, where 0 means 1) and the words left in the current buffer. One idle cycle follows each burst.
- R5: Once a burst has ended, no further word is sent while the request line stays low.
- R6: A request seen while the staging FIFO is empty and the channel is idle is held. The burst starts as soon as data arrives, even if the request has already dropped.
- R7: Memory reads run ahead of demand, one word at a time, only while the staging FIFO has a free slot and the buffer has bytes left. With no request, exactly eight reads are made and the channel then waits.
- R8: Within a run of a buffer, fetch addresses step by the access width from the start address. A request holds its address stable until memory accepts it.
- R9: With a nonzero skip count M in descriptor word 2 (bits 31:16) and a keep count N (bits 15:0), M bytes of address are skipped after every N bytes fetched. The length counts only fetched bytes.
- R10: At the end of a buffer that is not marked last (descriptor word 3, bit 8), the next fetch goes to the start address of the entry named by the next-index field (word 3, bits 7:0).
- R11: The done output pulses for one cycle, together with the acknowledge of the final word of the last buffer. Busy is low on the following cycle.
- R12: Writes to the control register are ignored while busy, so the width and burst fields read back unchanged.
- R13: The access-width code in control bits 2:1 selects 1, 2, 4 or 8 bytes per word (codes 0 to 3), and memory requests carry this code as their size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Register offset: 0 control, 1 status, 16 + 4*entry + word for descriptors |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the control and status offsets |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_req_size | output | 2 | Access-width code of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned |
| periph_req | input | 1 | Peripheral asks for data |
| periph_ack | output | 1 | A word is on periph_wdata this cycle |
| periph_wdata | output | 64 | Word for the peripheral FIFO register |
| xfer_done | output | 1 | Pulse with the final word of the chain |
| status_busy | output | 1 | Transfer in progress |
| status_error | output | 1 | Last start or link hit a bad descriptor |

## Verification
The bench builds the channel with its default values: four descriptor entries, an eight-word staging FIFO and a four-bit burst field. Eight words of staging are few enough that a ten-word buffer fills the FIFO and shows the read-ahead stall with no request. A burst of four then splits that buffer into bursts of 4, 4 and 2 before the next link, which puts both limits of the burst rule in view. Four entries allow a two-link chain, and the full range of width codes and a keep/skip pattern are exercised on single buffers.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int unsigned PTX_ADDR_W = 32;
    localparam int unsigned PTX_LEN_W  = 16;
    localparam int unsigned PTX_DATA_W = 64;
    localparam int unsigned PTX_LINK_W = 8;

    // One buffer descriptor as held in the internal table.
    typedef struct packed {
        logic [PTX_ADDR_W-1:0] base;
        logic [PTX_LEN_W-1:0]  len;
        logic [PTX_LEN_W-1:0]  keep_n;
        logic [PTX_LEN_W-1:0]  skip_m;
        logic [PTX_LINK_W-1:0] nxt;
        logic                  last;
    } ptx_desc_t;

    // One staged word with its boundary tags.
    typedef struct packed {
        logic                  end_buf;
        logic                  end_chain;
        logic [PTX_DATA_W-1:0] data;
    } ptx_word_t;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LOAD,
        F_RUN,
        F_WAIT,
        F_DRAIN
    } ptx_fetch_st_e;

    typedef enum logic [1:0] {
        B_IDLE,
        B_RUN,
        B_REST
    } ptx_burst_st_e;

    function automatic logic [PTX_LEN_W-1:0] ptx_width_bytes(input logic [1:0] code);
        return PTX_LEN_W'(1) << code;
    endfunction

endpackage

// File: rtl/ptx_cfg_regs.sv
module ptx_cfg_regs
    import ptx_pkg::*;
#(
    parameter int unsigned NUM_DESC = 4,
    parameter int unsigned BURST_W  = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_DESC),
    localparam int unsigned CFG_AW  = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic              error,
    output logic              start,
    output logic [1:0]        width_code,
    output logic [BURST_W-1:0] burst_beats,
    input  logic [IDX_W-1:0]  rd_idx,
    output ptx_desc_t         rd_desc
);

    typedef struct packed {
        logic [1:0]         width;
        logic [BURST_W-1:0] burst;
    } ctrl_t;

    ctrl_t     ctrl_d, ctrl_q;
    ptx_desc_t desc_d [NUM_DESC];
    ptx_desc_t desc_q [NUM_DESC];

    logic             in_table;
    logic [IDX_W-1:0] wr_idx;
    logic [1:0]       wr_word;
    logic             at_ctrl;
    logic             at_status;

    always_comb begin
        in_table  = cfg_addr[CFG_AW-1];
        wr_idx    = cfg_addr[IDX_W+1:2];
        wr_word   = cfg_addr[1:0];
        at_ctrl   = (cfg_addr == CFG_AW'(0));
        at_status = (cfg_addr == CFG_AW'(1));

        ctrl_d = ctrl_q;
        for (int i = 0; i < NUM_DESC; i++) begin
            desc_d[i] = desc_q[i];
        end
        start = 1'b0;

        if (cfg_wr) begin
            if (in_table) begin
                case (wr_word)
                    2'd0: desc_d[wr_idx].base = cfg_wdata[PTX_ADDR_W-1:0];
                    2'd1: desc_d[wr_idx].len  = cfg_wdata[PTX_LEN_W-1:0];
                    2'd2: begin
                        desc_d[wr_idx].keep_n = cfg_wdata[15:0];
                        desc_d[wr_idx].skip_m = cfg_wdata[31:16];
                    end
                    default: begin
                        desc_d[wr_idx].nxt  = cfg_wdata[PTX_LINK_W-1:0];
                        desc_d[wr_idx].last = cfg_wdata[8];
                    end
                endcase
            end else if (at_ctrl && !busy) begin
                ctrl_d.width = cfg_wdata[2:1];
                ctrl_d.burst = cfg_wdata[4 +: BURST_W];
                start        = cfg_wdata[0];
            end
        end

        width_code  = ctrl_q.width;
        burst_beats = (ctrl_q.burst == '0) ? BURST_W'(1) : ctrl_q.burst;
        rd_desc     = desc_q[rd_idx];

        cfg_rdata = 32'd0;
        if (!in_table && at_ctrl) begin
            cfg_rdata[2:1]          = ctrl_q.width;
            cfg_rdata[4 +: BURST_W] = ctrl_q.burst;
        end else if (!in_table && at_status) begin
            cfg_rdata[0] = busy;
            cfg_rdata[1] = error;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int i = 0; i < NUM_DESC; i++) begin
                desc_q[i] <= '0;
            end
        end else begin
            ctrl_q <= ctrl_d;
            for (int i = 0; i < NUM_DESC; i++) begin
                desc_q[i] <= desc_d[i];
            end
        end
    end

endmodule

// File: rtl/ptx_stage_fifo.sv
module ptx_stage_fifo
    import ptx_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  ptx_word_t        push_word,
    input  logic             pop,
    output ptx_word_t        head,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t      ptr_d, ptr_q;
    ptx_word_t slot_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.wr = ptr_q.wr + PTR_W'(1);
        end
        if (pop) begin
            ptr_d.rd = ptr_q.rd + PTR_W'(1);
        end
        case ({push, pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + CNT_W'(1);
            2'b01:   ptr_d.cnt = ptr_q.cnt - CNT_W'(1);
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
        head  = slot_q[ptr_q.rd];
        empty = (ptr_q.cnt == '0);
        count = ptr_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[ptr_q.wr] <= push_word;
        end
    end

endmodule

// File: rtl/ptx_fetch_ctrl.sv
module ptx_fetch_ctrl
    import ptx_pkg::*;
#(
    parameter int unsigned NUM_DESC   = 4,
    parameter int unsigned FIFO_DEPTH = 8,
    localparam int unsigned IDX_W     = $clog2(NUM_DESC),
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            width_code,
    output logic [IDX_W-1:0]      desc_idx,
    input  ptx_desc_t             desc,
    input  logic [CNT_W-1:0]      fifo_cnt,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PTX_ADDR_W-1:0] mem_req_addr,
    output logic [1:0]            mem_req_size,
    input  logic                  mem_rsp_valid,
    input  logic [PTX_DATA_W-1:0] mem_rsp_data,
    output logic                  push,
    output ptx_word_t             push_word,
    input  logic                  chain_done,
    output logic                  busy,
    output logic                  error
);

    typedef struct packed {
        ptx_fetch_st_e         st;
        logic [IDX_W-1:0]      idx;
        logic [PTX_ADDR_W-1:0] addr;
        logic [PTX_LEN_W-1:0]  rem;
        logic [PTX_LEN_W-1:0]  run;
        logic [PTX_LEN_W-1:0]  keep_n;
        logic [PTX_LEN_W-1:0]  skip_m;
        logic [IDX_W-1:0]      nxt;
        logic                  last;
        logic                  busy;
        logic                  err;
    } fetch_t;

    fetch_t                s_d, s_q;
    logic [PTX_LEN_W-1:0]  wbytes;
    logic [PTX_LEN_W-1:0]  wmask;
    logic                  bad_desc;
    logic                  end_of_buf;
    logic [PTX_ADDR_W-1:0] step_addr;
    logic [PTX_DATA_W-1:0] masked;

    always_comb begin
        wbytes = ptx_width_bytes(width_code);
        wmask  = wbytes - PTX_LEN_W'(1);

        bad_desc = (desc.len == '0)
                || ((desc.len & wmask) != '0)
                || ((desc.skip_m != '0)
                    && ((desc.keep_n == '0) || ((desc.keep_n & wmask) != '0)));

        end_of_buf = (s_q.rem == wbytes);
        step_addr  = s_q.addr + PTX_ADDR_W'(wbytes);

        for (int k = 0; k < PTX_DATA_W / 8; k++) begin
            masked[k*8 +: 8] = (PTX_LEN_W'(k) < wbytes) ? mem_rsp_data[k*8 +: 8] : 8'h00;
        end

        s_d  = s_q;
        push = 1'b0;
        push_word.data      = masked;
        push_word.end_buf   = end_of_buf;
        push_word.end_chain = end_of_buf && s_q.last;

        mem_req_valid = (s_q.st == F_RUN) && (fifo_cnt < CNT_W'(FIFO_DEPTH));

        case (s_q.st)
            F_IDLE: begin
                if (start) begin
                    s_d.idx  = '0;
                    s_d.st   = F_LOAD;
                    s_d.busy = 1'b1;
                    s_d.err  = 1'b0;
                end
            end
            F_LOAD: begin
                if (bad_desc) begin
                    s_d.err  = 1'b1;
                    s_d.busy = 1'b0;
                    s_d.st   = F_IDLE;
                end else begin
                    s_d.addr   = desc.base;
                    s_d.rem    = desc.len;
                    s_d.run    = desc.keep_n;
                    s_d.keep_n = desc.keep_n;
                    s_d.skip_m = desc.skip_m;
                    s_d.nxt    = desc.nxt[IDX_W-1:0];
                    s_d.last   = desc.last;
                    s_d.st     = F_RUN;
                end
            end
            F_RUN: begin
                if (mem_req_valid && mem_req_ready) begin
                    s_d.st = F_WAIT;
                end
            end
            F_WAIT: begin
                if (mem_rsp_valid) begin
                    push    = 1'b1;
                    s_d.rem = s_q.rem - wbytes;
                    if ((s_q.skip_m != '0) && (s_q.run == wbytes)) begin
                        s_d.addr = step_addr + PTX_ADDR_W'(s_q.skip_m);
                        s_d.run  = s_q.keep_n;
                    end else begin
                        s_d.addr = step_addr;
                        s_d.run  = s_q.run - wbytes;
                    end
                    if (end_of_buf) begin
                        if (s_q.last) begin
                            s_d.st = F_DRAIN;
                        end else begin
                            s_d.idx = s_q.nxt;
                            s_d.st  = F_LOAD;
                        end
                    end else begin
                        s_d.st = F_RUN;
                    end
                end
            end
            F_DRAIN: begin
                if (chain_done) begin
                    s_d.busy = 1'b0;
                    s_d.st   = F_IDLE;
                end
            end
            default: s_d.st = F_IDLE;
        endcase

        desc_idx     = s_q.idx;
        mem_req_addr = s_q.addr;
        mem_req_size = width_code;
        busy         = s_q.busy;
        error        = s_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: F_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ptx_burst_ctrl.sv
module ptx_burst_ctrl
    import ptx_pkg::*;
#(
    parameter int unsigned BURST_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  periph_req,
    input  logic [BURST_W-1:0]    burst_beats,
    input  logic                  fifo_empty,
    input  ptx_word_t             head,
    output logic                  pop,
    output logic                  periph_ack,
    output logic [PTX_DATA_W-1:0] periph_wdata,
    output logic                  chain_done,
    output logic                  in_idle
);

    typedef struct packed {
        ptx_burst_st_e         st;
        logic [BURST_W-1:0]    left;
        logic                  pend;
        logic                  ack;
        logic [PTX_DATA_W-1:0] data;
        logic                  done;
    } burst_t;

    burst_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        s_d.done = 1'b0;
        pop      = 1'b0;

        case (s_q.st)
            B_IDLE: begin
                if ((periph_req || s_q.pend) && !fifo_empty) begin
                    pop      = 1'b1;
                    s_d.ack  = 1'b1;
                    s_d.data = head.data;
                    s_d.done = head.end_chain;
                    s_d.pend = 1'b0;
                    s_d.left = burst_beats - BURST_W'(1);
                    s_d.st   = (head.end_buf || (burst_beats == BURST_W'(1))) ? B_REST : B_RUN;
                end else if (periph_req) begin
                    s_d.pend = 1'b1;
                end
            end
            B_RUN: begin
                if (!fifo_empty) begin
                    pop      = 1'b1;
                    s_d.ack  = 1'b1;
                    s_d.data = head.data;
                    s_d.done = head.end_chain;
                    s_d.left = s_q.left - BURST_W'(1);
                    s_d.st   = (head.end_buf || (s_q.left == BURST_W'(1))) ? B_REST : B_RUN;
                end
            end
            default: s_d.st = B_IDLE;
        endcase

        periph_ack   = s_q.ack;
        periph_wdata = s_q.data;
        chain_done   = s_q.done;
        in_idle      = (s_q.st == B_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: B_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ptx_dma_chan.sv
module ptx_dma_chan
    import ptx_pkg::*;
#(
    parameter int unsigned NUM_DESC   = 4,
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned BURST_W    = 4,
    localparam int unsigned CFG_AW    = $clog2(NUM_DESC) + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PTX_ADDR_W-1:0] mem_req_addr,
    output logic [1:0]            mem_req_size,
    input  logic                  mem_rsp_valid,
    input  logic [PTX_DATA_W-1:0] mem_rsp_data,
    input  logic                  periph_req,
    output logic                  periph_ack,
    output logic [PTX_DATA_W-1:0] periph_wdata,
    output logic                  xfer_done,
    output logic                  status_busy,
    output logic                  status_error
);

    localparam int unsigned IDX_W = $clog2(NUM_DESC);
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

    logic               busy;
    logic               error;
    logic               start;
    logic [1:0]         width_code;
    logic [BURST_W-1:0] burst_beats;
    logic [IDX_W-1:0]   desc_idx;
    ptx_desc_t          desc;
    logic               push;
    ptx_word_t          push_word;
    logic               pop;
    ptx_word_t          head;
    logic               fifo_empty;
    logic [CNT_W-1:0]   fifo_cnt;
    logic               chain_done;
    logic               burst_idle;

    ptx_cfg_regs #(
        .NUM_DESC (NUM_DESC),
        .BURST_W  (BURST_W)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .busy        (busy),
        .error       (error),
        .start       (start),
        .width_code  (width_code),
        .burst_beats (burst_beats),
        .rd_idx      (desc_idx),
        .rd_desc     (desc)
    );

    ptx_fetch_ctrl #(
        .NUM_DESC   (NUM_DESC),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) i_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .width_code    (width_code),
        .desc_idx      (desc_idx),
        .desc          (desc),
        .fifo_cnt      (fifo_cnt),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_size  (mem_req_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .push          (push),
        .push_word     (push_word),
        .chain_done    (chain_done),
        .busy          (busy),
        .error         (error)
    );

    ptx_stage_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .count     (fifo_cnt)
    );

    ptx_burst_ctrl #(
        .BURST_W (BURST_W)
    ) i_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .periph_req   (periph_req),
        .burst_beats  (burst_beats),
        .fifo_empty   (fifo_empty),
        .head         (head),
        .pop          (pop),
        .periph_ack   (periph_ack),
        .periph_wdata (periph_wdata),
        .chain_done   (chain_done),
        .in_idle      (burst_idle)
    );

    assign xfer_done    = chain_done;
    assign status_busy  = busy;
    assign status_error = error;

endmodule

// File: rtl/ptx_chan_checker.sv
module ptx_chan_checker
    import ptx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned BURST_W    = 4,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  status_busy,
    input logic                  xfer_done,
    input logic                  periph_ack,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic [PTX_ADDR_W-1:0] mem_req_addr,
    input logic [CNT_W-1:0]      fifo_cnt,
    input logic                  burst_idle,
    input logic [BURST_W-1:0]    burst_beats
);

    logic [7:0] beat_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_run <= '0;
        end else if (burst_idle && !periph_ack) begin
            beat_run <= '0;
        end else if (periph_ack) begin
            beat_run <= beat_run + 8'd1;
        end
    end

    // R7: the staging FIFO never holds more than its depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    // R4: words acknowledged in one burst stay within the burst length
    a_r4_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_run + 8'(periph_ack)) <= 8'(burst_beats));

    // R2: no memory traffic while the channel is not busy
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !status_busy |-> !mem_req_valid);

    // R8: a stalled memory request keeps its address
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11: done is a single-cycle pulse coincident with a word
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> periph_ack ##1 !xfer_done);

    // R11: busy falls right after done
    a_r11_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !status_busy);

endmodule

bind ptx_dma_chan ptx_chan_checker #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .BURST_W    (BURST_W)
) i_ptx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .status_busy   (status_busy),
    .xfer_done     (xfer_done),
    .periph_ack    (periph_ack),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .fifo_cnt      (fifo_cnt),
    .burst_idle    (burst_idle),
    .burst_beats   (burst_beats)
);

// File: tb/test_ptx_dma_chan.sv
module test_ptx_dma_chan;

    localparam int CFG_AW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              mem_req_valid;
    logic              mem_ready_en = 1'b1;
    logic [31:0]       mem_req_addr;
    logic [1:0]        mem_req_size;
    logic              mem_rsp_valid = 1'b0;
    logic [63:0]       mem_rsp_data = '0;
    logic              periph_req = 1'b0;
    logic              periph_ack;
    logic [63:0]       periph_wdata;
    logic              xfer_done;
    logic              status_busy;
    logic              status_error;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [63:0] beat_data [64];
    int          beat_cyc  [64];
    int          nbeat = 0;
    logic [31:0] mreq_addr [64];
    logic [1:0]  mreq_size [64];
    int          nmreq = 0;
    int          ndone = 0;
    int          done_cyc = 0;

    always #4 clk = ~clk;

    ptx_dma_chan i_ptx_dma_chan (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_ready_en),
        .mem_req_addr  (mem_req_addr),
        .mem_req_size  (mem_req_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .periph_req    (periph_req),
        .periph_ack    (periph_ack),
        .periph_wdata  (periph_wdata),
        .xfer_done     (xfer_done),
        .status_busy   (status_busy),
        .status_error  (status_error)
    );

    function automatic logic [63:0] mem_pattern(input logic [31:0] a);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'(a + 32'(k));
        return v;
    endfunction

    function automatic logic [63:0] exp_word(input logic [31:0] a, input int w);
        logic [63:0] v = '0;
        for (int k = 0; k < w; k++) v[k*8 +: 8] = 8'(a + 32'(k));
        return v;
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_ready_en) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_pattern(mem_req_addr);
        end
    end

    // Monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (periph_ack && nbeat < 64) begin
                beat_data[nbeat] = periph_wdata;
                beat_cyc[nbeat]  = cyc;
                nbeat++;
            end
            if (mem_req_valid && mem_ready_en && nmreq < 64) begin
                mreq_addr[nmreq] = mem_req_addr;
                mreq_size[nmreq] = mem_req_size;
                nmreq++;
            end
            if (xfer_done) begin
                ndone++;
                done_cyc = cyc;
            end
            cyc++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = CFG_AW'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic cfg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = CFG_AW'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic set_desc(input int idx, input logic [31:0] base, input int len,
                            input int keep_n, input int skip_m, input int nxt, input bit last);
        cfg_write(16 + 4*idx + 0, base);
        cfg_write(16 + 4*idx + 1, 32'(len));
        cfg_write(16 + 4*idx + 2, (32'(skip_m) << 16) | 32'(keep_n));
        cfg_write(16 + 4*idx + 3, (32'(last) << 8) | 32'(nxt));
    endtask

    task automatic go(input int wcode, input int burst);
        cfg_write(0, (32'(burst) << 4) | (32'(wcode) << 1) | 32'd1);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (status_busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(!status_busy, tag, 64'(status_busy), 64'd0);
    endtask

    task automatic check_data(input int b0, input int m0, input int cnt, input int w, input string tag);
        for (int i = 0; i < cnt; i++) begin
            check(beat_data[b0+i] == exp_word(mreq_addr[m0+i], w), tag,
                  beat_data[b0+i], exp_word(mreq_addr[m0+i], w));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(!status_busy && !status_error, "R1 status outputs", {status_busy, status_error}, 0);
        check(!periph_ack && !mem_req_valid && !xfer_done, "R1 handshake outputs",
              {periph_ack, mem_req_valid, xfer_done}, 0);
        cfg_read(0, d);
        check(d == 32'd0, "R1 control reg", d, 0);
        cfg_read(1, d);
        check(d == 32'd0, "R1 status reg", d, 0);
    endtask

    task automatic t_reject();
        logic [31:0] d;
        int m0 = nmreq;
        set_desc(0, 32'h80, 6, 0, 0, 0, 1'b1);
        go(2, 4);
        repeat (6) @(negedge clk);
        cfg_read(1, d);
        check(d == 32'd2, "R2 odd length refused", d, 2);
        check(nmreq == m0, "R2 no memory read", nmreq - m0, 0);
        set_desc(0, 32'h80, 0, 0, 0, 0, 1'b1);
        go(0, 1);
        repeat (6) @(negedge clk);
        cfg_read(1, d);
        check(d == 32'd2, "R2 zero length refused", d, 2);
        check(nmreq == m0, "R2 still no memory read", nmreq - m0, 0);
    endtask

    task automatic t_chain_bursts();
        logic [31:0] d;
        int b0 = nbeat;
        int m0 = nmreq;
        int d0 = ndone;
        int runs[8];
        int nrun = 0;
        set_desc(0, 32'h100, 40, 0, 0, 1, 1'b0);
        set_desc(1, 32'h400, 8, 0, 0, 0, 1'b1);
        go(2, 4);
        repeat (40) @(negedge clk);
        check(nmreq - m0 == 8, "R7 read-ahead stops at eight words", nmreq - m0, 8);
        check(nbeat == b0, "R5 no words without request", nbeat - b0, 0);
        cfg_write(0, 32'h0000_0091);
        cfg_read(0, d);
        check(d == 32'h44, "R12 control write ignored while busy", d, 32'h44);
        periph_req = 1'b1;
        wait_idle("R11 chain finishes");
        repeat (4) @(negedge clk);
        periph_req = 1'b0;
        check(nbeat - b0 == 12, "R3 word count", nbeat - b0, 12);
        check(nmreq - m0 == 12, "R10 read count", nmreq - m0, 12);
        for (int i = 0; i < 10; i++) begin
            check(mreq_addr[m0+i] == 32'h100 + 32'(4*i), "R8 address step",
                  mreq_addr[m0+i], 32'h100 + 32'(4*i));
        end
        check(mreq_addr[m0+10] == 32'h400, "R10 link start", mreq_addr[m0+10], 32'h400);
        check(mreq_addr[m0+11] == 32'h404, "R10 link second", mreq_addr[m0+11], 32'h404);
        check(mreq_size[m0] == 2'd2, "R13 size code", mreq_size[m0], 2);
        check_data(b0, m0, 12, 4, "R3 word data");
        for (int i = b0; i < nbeat; i++) begin
            if (i == b0 || beat_cyc[i] != beat_cyc[i-1] + 1) begin
                if (nrun < 8) nrun++;
                runs[nrun-1] = 0;
            end
            runs[nrun-1]++;
        end
        check(nrun == 4, "R4 burst count", nrun, 4);
        check(runs[0] == 4 && runs[1] == 4, "R4 full bursts", {32'(runs[0]), 32'(runs[1])}, {32'd4, 32'd4});
        check(runs[2] == 2, "R4 burst cut at buffer end", runs[2], 2);
        check(runs[3] == 2, "R4 linked buffer burst", runs[3], 2);
        check(ndone - d0 == 1, "R11 one done pulse", ndone - d0, 1);
        check(done_cyc == beat_cyc[nbeat-1], "R11 done with final word", done_cyc, beat_cyc[nbeat-1]);
    endtask

    task automatic t_gap();
        int b0 = nbeat;
        int m0 = nmreq;
        logic [31:0] exp_a [6];
        exp_a = '{32'h200, 32'h202, 32'h208, 32'h20A, 32'h210, 32'h212};
        set_desc(0, 32'h200, 12, 4, 4, 0, 1'b1);
        periph_req = 1'b1;
        go(1, 8);
        wait_idle("R9 gap buffer finishes");
        repeat (3) @(negedge clk);
        periph_req = 1'b0;
        check(nmreq - m0 == 6, "R9 read count", nmreq - m0, 6);
        for (int i = 0; i < 6; i++) begin
            check(mreq_addr[m0+i] == exp_a[i], "R9 skip address", mreq_addr[m0+i], exp_a[i]);
        end
        check(nbeat - b0 == 6, "R9 word count", nbeat - b0, 6);
        check_data(b0, m0, 6, 2, "R13 two-byte words");
    endtask

    task automatic t_widths();
        int b0 = nbeat;
        int m0 = nmreq;
        set_desc(0, 32'h33, 3, 0, 0, 0, 1'b1);
        periph_req = 1'b1;
        go(0, 2);
        wait_idle("R13 byte buffer finishes");
        check(nbeat - b0 == 3, "R13 byte word count", nbeat - b0, 3);
        check_data(b0, m0, 3, 1, "R13 one-byte words");
        check(beat_data[b0] == 64'h33, "R3 upper bytes zero", beat_data[b0], 64'h33);
        b0 = nbeat;
        m0 = nmreq;
        set_desc(0, 32'h40, 16, 0, 0, 0, 1'b1);
        go(3, 2);
        wait_idle("R13 dword buffer finishes");
        repeat (3) @(negedge clk);
        periph_req = 1'b0;
        check(nbeat - b0 == 2, "R13 dword count", nbeat - b0, 2);
        check(mreq_size[m0] == 2'd3, "R13 dword size code", mreq_size[m0], 3);
        check(beat_data[b0] == 64'h4746_4544_4342_4140, "R13 eight-byte word",
              beat_data[b0], 64'h4746_4544_4342_4140);
    endtask

    task automatic t_pending();
        int b0 = nbeat;
        int m0 = nmreq;
        mem_ready_en = 1'b0;
        set_desc(0, 32'h500, 16, 0, 0, 0, 1'b1);
        go(2, 2);
        periph_req = 1'b1;
        repeat (2) @(negedge clk);
        periph_req = 1'b0;
        repeat (5) @(negedge clk);
        check(nbeat == b0, "R6 nothing before data", nbeat - b0, 0);
        mem_ready_en = 1'b1;
        repeat (30) @(negedge clk);
        check(nbeat - b0 == 2, "R6 held request served", nbeat - b0, 2);
        check(status_busy, "R5 waits for request", 64'(status_busy), 1);
        periph_req = 1'b1;
        wait_idle("R5 resumes on request");
        repeat (3) @(negedge clk);
        periph_req = 1'b0;
        check(nbeat - b0 == 4, "R5 total words", nbeat - b0, 4);
        check_data(b0, m0, 4, 4, "R3 pending data");
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_reject();
        t_chain_bursts();
        t_gap();
        t_widths();
        t_pending();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule